// File: doc/BRIEF.md
# Tiered Instruction Decode Router

This block sits between instruction fetch and the issue logic. It takes one 16-bit instruction at a time over a valid/ready handshake and sorts it into one of four handling tiers, chosen by a two-bit class field. A plain instruction goes out unchanged as a single micro-operation. An instruction that both accesses memory and updates its base register is split into two plain micro-operations. A string-move instruction is handed to a straight-line sequencer that emits a fixed run of load/store pairs set by its byte count. A legacy instruction produces no micro-operations and instead raises a trap pulse for software emulation.

The output is a registered stream of micro-operations. Each carries a three-bit kind tag and a 16-bit payload, under its own valid/ready handshake. Every instruction reaches the output register in the cycle it is accepted, so a plain instruction has one cycle of latency. Back-to-back plain instructions flow at one per cycle. The cracking and sequencing state never sits in front of that path.

Top module: `idr_router`

## Requirements
- R1: An instruction of class 00 is emitted unchanged as one micro-operation of kind PASS (code 0), valid on the output in the cycle after it is accepted.
- R2: The class is taken from instruction bits [15:14]: 00 plain, 01 memory access with base update, 10 string move, 11 trapped legacy instruction.
- R3: A class 01 instruction yields a MEM micro-operation (kind 1, payload = instruction with bits [15:14] cleared), followed directly by an ADDU micro-operation (kind 2, payload = {6'b0, bits [9:6], bits [5:0]}).
- R4: A class 10 instruction with byte count c = bits [3:0] yields floor(c/4) + (c mod 4 != 0) pairs. Pair p is an SLD (kind 3) and then an SST (kind 4), both with payload {bits[13:10]+p mod 16, bits[9:6], 6-bit offset 4p, 2-bit size}. The size is 3 for a full word and (c mod 4)-1 for the final partial word.
- R5: A class 10 instruction with a byte count of zero is consumed and emits no micro-operation.
- R6: A class 11 instruction emits no micro-operation. It drives trap_valid high for exactly the cycle after it is accepted, with trap_op = instruction bits [13:8]. Trap_valid is low in every other cycle.
- R7: in_ready is low while any micro-operation of the previous instruction is still unaccepted, except in the cycle in which its last one is being accepted.
- R8: While out_valid is high and out_ready is low, out_valid, out_kind and out_data stay unchanged into the next cycle, and the sequencer does not advance.
- R9: After reset, out_valid and trap_valid are low and in_ready is high.
- R10: When no micro-operation is pending, or the only pending one is being accepted, in_ready is high. This lets plain instructions stream at one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Router can take an instruction |
| in_instr | input | 16 | Instruction word |
| out_valid | output | 1 | Micro-operation available |
| out_ready | input | 1 | Downstream accepts the micro-operation |
| out_kind | output | 3 | Micro-operation kind: 0 PASS, 1 MEM, 2 ADDU, 3 SLD, 4 SST |
| out_data | output | 16 | Micro-operation payload |
| trap_valid | output | 1 | One-cycle emulation trap request |
| trap_op | output | 6 | Opcode field of the trapped instruction |

## Verification
The bench builds the router with its default format constants: a four-bit byte count and a four-byte word. With these values the sequencer's full range is reachable, from zero pairs up to four pairs (eight micro-operations) for a count of fifteen. Directed cases cover counts of zero, exact multiples of four and the largest count. Mixed random traffic with random downstream stalls covers back-to-back traps, cracking under stalls, and the cycle in which a new instruction is accepted just as the last micro-operation of the previous one leaves.

// File: rtl/idr_pkg.sv
package idr_pkg;

  localparam int INSN_W     = 16;
  localparam int CLS_W      = 2;
  localparam int CNT_W      = 4;
  localparam int WORD_BYTES = 4;
  localparam int TRAP_W     = 6;
  localparam int KIND_W     = 3;
  localparam int MAX_PAIRS  = ((1 << CNT_W) - 1 + WORD_BYTES - 1) / WORD_BYTES;
  localparam int STEP_W     = $clog2(2 * MAX_PAIRS) + 1;
  localparam int PAIR_W     = $clog2(MAX_PAIRS) + 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_SIMPLE = 2'd0,
    CLS_UPD    = 2'd1,
    CLS_STR    = 2'd2,
    CLS_TRAP   = 2'd3
  } cls_e;

  typedef enum logic [KIND_W-1:0] {
    UK_PASS = 3'd0,
    UK_MEM  = 3'd1,
    UK_ADDU = 3'd2,
    UK_SLD  = 3'd3,
    UK_SST  = 3'd4
  } ukind_e;

  typedef struct packed {
    ukind_e              kind;
    logic [INSN_W-1:0]   data;
  } uop_t;

  // Number of load/store pairs a string instruction needs.
  function automatic logic [PAIR_W-1:0] str_pairs(input logic [INSN_W-1:0] ins);
    logic [PAIR_W-1:0] words;
    logic              part;
    words = PAIR_W'(ins[CNT_W-1:2]);
    part  = (ins[1:0] != 2'd0);
    return words + PAIR_W'(part);
  endfunction

  // Total micro-operations of a string instruction.
  function automatic logic [STEP_W-1:0] str_steps(input logic [INSN_W-1:0] ins);
    return STEP_W'({str_pairs(ins), 1'b0});
  endfunction

  // Micro-operation number 'step' of a string instruction.
  function automatic uop_t str_uop(input logic [INSN_W-1:0] ins,
                                   input logic [STEP_W-1:0] step);
    logic [3:0] pair;
    logic [3:0] rt;
    logic [1:0] size;
    uop_t       u;
    pair = 4'(step >> 1);
    rt   = ins[13:10] + pair;
    if (pair < {2'b00, ins[CNT_W-1:2]}) size = 2'd3;
    else                                size = ins[1:0] - 2'd1;
    u.kind = step[0] ? UK_SST : UK_SLD;
    u.data = {rt, ins[9:6], pair, 2'b00, size};
    return u;
  endfunction

  function automatic uop_t crack_mem(input logic [INSN_W-1:0] ins);
    uop_t u;
    u.kind = UK_MEM;
    u.data = {2'b00, ins[INSN_W-3:0]};
    return u;
  endfunction

  function automatic uop_t crack_upd(input logic [INSN_W-1:0] ins);
    uop_t u;
    u.kind = UK_ADDU;
    u.data = {6'b000000, ins[9:6], ins[5:0]};
    return u;
  endfunction

endpackage

// File: rtl/idr_crack.sv
module idr_crack
  import idr_pkg::*;
(
  input  logic [INSN_W-1:0] new_instr,
  input  logic [INSN_W-1:0] held_instr,
  output uop_t              mem_uop,
  output uop_t              upd_uop
);
  // The access half comes from the incoming word, the base update from the held copy.
  assign mem_uop = crack_mem(new_instr);
  assign upd_uop = crack_upd(held_instr);
endmodule

// File: rtl/idr_useq.sv
module idr_useq
  import idr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic              seq_step,
  input  logic [INSN_W-1:0] held_instr,
  output uop_t              nxt_uop,
  output logic              nxt_last
);
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nx;

  assign step_nx  = step_q + STEP_W'(1);
  assign nxt_uop  = str_uop(held_instr, step_nx);
  assign nxt_last = (step_nx + STEP_W'(1)) == str_steps(held_instr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         step_q <= '0;
    else if (seq_start) step_q <= '0;
    else if (seq_step)  step_q <= step_nx;
  end

endmodule

// File: rtl/idr_trap.sv
module idr_trap
  import idr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_fire,
  input  logic [TRAP_W-1:0] trap_code,
  output logic              trap_valid,
  output logic [TRAP_W-1:0] trap_op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_op    <= '0;
    end else begin
      trap_valid <= trap_fire;
      if (trap_fire) trap_op <= trap_code;
    end
  end
endmodule

// File: rtl/idr_router.sv
module idr_router
  import idr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_instr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [15:0]       out_data,
  output logic              trap_valid,
  output logic [5:0]        trap_op
);

  typedef enum logic [1:0] {ST_IDLE, ST_CRACK, ST_SEQ} state_e;

  state_e            state_q, state_d;
  uop_t              out_q, load_uop;
  logic              load_en;
  logic [INSN_W-1:0] hold_q;

  // Named internal events
  cls_e  in_cls;
  logic  in_fire, out_fire, out_adv;
  logic  seq_start, seq_step, trap_fire, str_empty;
  uop_t  mem_uop, upd_uop, seq_uop;
  logic  seq_last;

  assign in_cls    = cls_e'(in_instr[15:14]);
  assign out_adv   = !out_valid || out_ready;
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = (state_q == ST_IDLE) && out_adv;
  assign in_fire   = in_valid && in_ready;
  assign str_empty = (str_pairs(in_instr) == '0);
  assign seq_start = in_fire && (in_cls == CLS_STR) && !str_empty;
  assign seq_step  = (state_q == ST_SEQ) && out_adv;
  assign trap_fire = in_fire && (in_cls == CLS_TRAP);

  idr_crack i_crack (
    .new_instr  (in_instr),
    .held_instr (hold_q),
    .mem_uop    (mem_uop),
    .upd_uop    (upd_uop)
  );

  idr_useq i_useq (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_start  (seq_start),
    .seq_step   (seq_step),
    .held_instr (hold_q),
    .nxt_uop    (seq_uop),
    .nxt_last   (seq_last)
  );

  idr_trap i_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_fire  (trap_fire),
    .trap_code  (in_instr[13:8]),
    .trap_valid (trap_valid),
    .trap_op    (trap_op)
  );

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    load_uop = out_q;
    unique case (state_q)
      ST_IDLE: begin
        if (in_fire) begin
          unique case (in_cls)
            CLS_SIMPLE: begin
              load_en       = 1'b1;
              load_uop.kind = UK_PASS;
              load_uop.data = in_instr;
            end
            CLS_UPD: begin
              load_en  = 1'b1;
              load_uop = mem_uop;
              state_d  = ST_CRACK;
            end
            CLS_STR: begin
              if (!str_empty) begin
                load_en  = 1'b1;
                load_uop = str_uop(in_instr, '0);
                state_d  = ST_SEQ;
              end
            end
            default: ;
          endcase
        end
      end
      ST_CRACK: begin
        if (out_adv) begin
          load_en  = 1'b1;
          load_uop = upd_uop;
          state_d  = ST_IDLE;
        end
      end
      ST_SEQ: begin
        if (out_adv) begin
          load_en  = 1'b1;
          load_uop = seq_uop;
          if (seq_last) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      out_valid <= 1'b0;
      out_q     <= '{kind: UK_PASS, data: '0};
      hold_q    <= '0;
    end else begin
      state_q <= state_d;
      if (in_fire) hold_q <= in_instr;
      if (load_en) begin
        out_valid <= 1'b1;
        out_q     <= load_uop;
      end else if (out_fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_kind = out_q.kind;
  assign out_data = out_q.data;

  AST_PASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cls == CLS_SIMPLE |=> out_valid && out_kind == UK_PASS && out_data == $past(in_instr)); // R1
  AST_CLASS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cls == CLS_UPD |=> out_valid && out_kind == UK_MEM); // R2
  AST_CRACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_kind == UK_MEM |=> out_valid && out_kind == UK_ADDU); // R3
  AST_STR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_kind == UK_SLD |=> out_valid && out_kind == UK_SST); // R4
  AST_STR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cls == CLS_STR && in_instr[3:0] == 4'd0 |=> !out_valid); // R5
  AST_TRAP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cls == CLS_TRAP |=> trap_valid && trap_op == $past(in_instr[13:8])); // R6
  AST_TRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_fire && in_cls == CLS_TRAP) |=> !trap_valid); // R6
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_IDLE |-> !in_ready); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_data)); // R8
  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE && !out_valid |-> in_ready); // R10

endmodule

// File: tb/test_idr_router.sv
module test_idr_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_instr;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_kind;
  logic [15:0] out_data;
  logic        trap_valid;
  logic [5:0]  trap_op;

  idr_router i_idr_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_instr   (in_instr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_kind   (out_kind),
    .out_data   (out_data),
    .trap_valid (trap_valid),
    .trap_op    (trap_op)
  );

  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  logic [18:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected micro-operation list, written from the requirements (R2 picks the tier).
  function automatic void expand(input logic [15:0] ins);
    int left, idx, take;
    case (ins[15:14])
      2'b00: exp_q.push_back({3'd0, ins});                                // R1
      2'b01: begin                                                        // R3
        exp_q.push_back({3'd1, 2'b00, ins[13:0]});
        exp_q.push_back({3'd2, 6'd0, ins[9:6], ins[5:0]});
      end
      2'b10: begin                                                        // R4, R5
        left = int'(ins[3:0]);
        idx  = 0;
        while (left > 0) begin
          take = (left >= 4) ? 4 : left;
          exp_q.push_back({3'd3, 4'(int'(ins[13:10]) + idx), ins[9:6], 6'(idx * 4), 2'(take - 1)});
          exp_q.push_back({3'd4, 4'(int'(ins[13:10]) + idx), ins[9:6], 6'(idx * 4), 2'(take - 1)});
          left -= take;
          idx++;
        end
      end
      default: ;                                                          // R6
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] k);
    if (k == 3'd0) return "R1";
    if (k == 3'd1 || k == 3'd2) return "R3";
    return "R4";
  endfunction

  logic [15:0] directed [12];
  initial begin
    directed[0]  = 16'h1234;              // plain
    directed[1]  = {2'b01, 14'h2ABC};     // crack
    directed[2]  = {2'b10, 10'h155, 4'd0};  // R5 empty string
    directed[3]  = {2'b10, 10'h0C3, 4'd4};  // one full word
    directed[4]  = {2'b10, 10'h3FF, 4'd15}; // largest count, register wrap
    directed[5]  = {2'b10, 10'h040, 4'd3};  // partial only
    directed[6]  = {2'b11, 6'h2D, 8'h00};   // trap
    directed[7]  = {2'b11, 6'h11, 8'hFF};   // back-to-back trap
    directed[8]  = {2'b01, 14'h0001};
    directed[9]  = {2'b10, 10'h001, 4'd8};
    directed[10] = 16'h3FFF;
    directed[11] = 16'h0000;
  end

  initial begin
    int          cyc       = 0;
    int          sent      = 0;
    bit          need_new  = 1'b1;
    bit          trap_due  = 1'b0;
    logic [5:0]  trap_exp  = '0;
    bit          hold_pend = 1'b0;
    logic [18:0] hold_val  = '0;
    logic [18:0] e;
    bit          exp_rdy;
    bit          done      = 1'b0;
    localparam int N_RAND = 4000;
    localparam int LIMIT  = 150000;

    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(trap_valid == 1'b0, "R9 trap_valid", int'(trap_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);

    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        break;
      end
      // R6: trap pulse exactly one cycle after acceptance, nowhere else
      if (trap_due || trap_valid) begin
        chk(trap_valid == trap_due, "R6 trap_valid", int'(trap_valid), int'(trap_due));
        if (trap_due) chk(trap_op == trap_exp, "R6 trap_op", int'(trap_op), int'(trap_exp));
      end
      trap_due = 1'b0;
      // R8: stalled output held
      if (hold_pend) begin
        chk(out_valid && {out_kind, out_data} == hold_val, "R8 held op",
            int'({out_valid, out_kind, out_data}), int'({1'b1, hold_val}));
        hold_pend = 1'b0;
      end
      // drive inputs
      if (need_new) begin
        if (sent < 12) begin
          in_valid = 1'b1; in_instr = directed[sent]; sent++; need_new = 1'b0;
        end else if (sent < 12 + N_RAND) begin
          if (($urandom % 5) != 0) begin
            in_valid = 1'b1; in_instr = 16'($urandom); sent++; need_new = 1'b0;
          end else in_valid = 1'b0;
        end else in_valid = 1'b0;
      end
      out_ready = (cyc < 40) ? ((cyc % 3) != 0) : (($urandom % 4) != 0);
      #1;
      // output side
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 spurious op", int'({out_kind, out_data}), 0);
        end else if (out_ready) begin
          e = exp_q.pop_front();
          chk({out_kind, out_data} == e, tag_of(e[18:16]), int'({out_kind, out_data}), int'(e));
        end else begin
          hold_pend = 1'b1;
          hold_val  = {out_kind, out_data};
        end
      end
      // R7 and R10: ready exactly when nothing of the previous instruction remains
      exp_rdy = (exp_q.size() == 0);
      chk(in_ready == exp_rdy, exp_rdy ? "R10 in_ready" : "R7 in_ready", int'(in_ready), int'(exp_rdy));
      // input side
      if (in_valid && in_ready) begin
        expand(in_instr);
        if (in_instr[15:14] == 2'b11) begin
          trap_due = 1'b1;
          trap_exp = in_instr[13:8];
        end
        need_new = 1'b1;
      end
      if (sent >= 12 + N_RAND && need_new && exp_q.size() == 0 && !trap_due) done = 1'b1;
    end

    @(negedge clk);
    chk(exp_q.size() == 0, "R4 leftover ops", exp_q.size(), 0);
    chk(out_valid == 1'b0 && trap_valid == 1'b0, "R6 quiet end",
        int'({out_valid, trap_valid}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule